// File: doc/BRIEF.md
# Checkpointed Writeback Filter

This block decides, for every computed physical-register result, whether the result is worth writing into the front-end register file. A result is worth keeping only if some mapping can still name its register: the live rename mapping, or a mapping saved at a branch or an instruction that may trap. Results for any other register are dropped, which saves register file write energy.

Each mapping is a bit vector with one bit per physical register. The block holds the live vector and a small stack of saved vectors. Rename logic sets and clears bits in the live vector. Decode pushes a snapshot at each branch or trap-prone instruction. Resolution releases the oldest snapshot. A mispredict rolls the live vector back to a chosen snapshot and discards every snapshot younger than it. The filter mask is the OR of the live vector and all occupied snapshot slots. Several writeback sources (pre-execution units and the out-of-order back end) are filtered side by side against the same mask.

Top module: `wb_filter`

## Requirements
- R1: After reset the live vector holds exactly the physical registers 0 to ARCH_REGS-1, the stack is empty (ckptCount = 0) and ckptFull is low.
- R2: wbEn[w] is high in the same cycle as wbReq[w] exactly when the destination in wbDst slice w (bits w*IDX_W upward) is below NUM_PREGS and its bit is set in the OR of the live vector and every occupied snapshot; a destination at or above NUM_PREGS is never enabled.
- R3: A rename set or clear changes the live vector from the next cycle on; if both name the same register in one cycle, the set wins.
- R4: A push stores the live vector as it stood before that cycle's rename update and raises ckptCount by one, so a register cleared in the same cycle stays writable while the snapshot is held.
- R5: ckptFull is high exactly when ckptCount equals DEPTH; a push in that state changes nothing.
- R6: A commit (ckptPop) releases the oldest snapshot, whose bits then stop counting; a commit on an empty stack changes nothing.
- R7: A restore with restoreIdx k (0 names the oldest snapshot) and k below ckptCount copies snapshot k into the live vector and sets ckptCount to k; in that cycle push, commit and rename are ignored. A restore with k at or above ckptCount has no effect, and the cycle's other operations proceed.
- R8: The writeback ports are filtered independently of each other, each against the same mask.
- R9: A push and a commit in the same cycle on a stack that is not full leave ckptCount unchanged, with the new snapshot becoming the youngest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| renSetValid | input | 1 | Set a bit in the live vector |
| renSetIdx | input | IDX_W | Register to set |
| renClrValid | input | 1 | Clear a bit in the live vector |
| renClrIdx | input | IDX_W | Register to clear |
| ckptPush | input | 1 | Save the live vector as a new youngest snapshot |
| ckptPop | input | 1 | Release the oldest snapshot |
| restoreValid | input | 1 | Roll back to a snapshot |
| restoreIdx | input | SLOT_W | Snapshot position counted from the oldest |
| wbReq | input | NUM_WB | Writeback request per port |
| wbDst | input | NUM_WB*IDX_W | Destination register per port |
| wbEn | output | NUM_WB | Write permitted per port |
| ckptCount | output | CNT_W | Number of held snapshots |
| ckptFull | output | 1 | Stack full, decode must stall pushes |

## Verification
After every operation the bench sweeps every destination code on both ports, including the codes above the register count, and compares each enable with a mask it rebuilds from its own vector-and-queue model; this separates bits held only by the live vector from bits held only by a snapshot. Push with a same-cycle clear, push on a full stack, commit on an empty stack, same-cycle push and commit, in-range and out-of-range restores combined with other operations, and a set and clear on one register are each driven on purpose. A long mixed sweep of sets, clears, pushes and commits then exercises the circular slot wrap.

// File: rtl/wbf_pkg.sv
package wbf_pkg;
  localparam int SLOT_W_MAX = 8;

  // Strobes from the stack control into the vector datapath.
  typedef struct packed {
    logic                  push;
    logic                  restore;
    logic [SLOT_W_MAX-1:0] pushSlot;
    logic [SLOT_W_MAX-1:0] restoreSlot;
  } wbf_strb_t;
endpackage

// File: rtl/wbf_ctrl.sv
module wbf_ctrl
  import wbf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SLOT_W = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic              restore,
  input  logic [SLOT_W-1:0] restoreIdx,
  output wbf_strb_t         strb,
  output logic [DEPTH-1:0]  liveSlots,
  output logic [CNT_W-1:0]  count,
  output logic              full
);
  // DEPTH must be a power of two so that the head pointer wraps naturally.
  logic [SLOT_W-1:0] head;
  logic rstOk, pushOk, popOk;

  assign full   = (count == CNT_W'(DEPTH));
  assign rstOk  = restore && (CNT_W'(restoreIdx) < count);
  assign pushOk = push && !rstOk && !full;
  assign popOk  = pop && !rstOk && (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      count <= '0;
    end else if (rstOk) begin
      count <= CNT_W'(restoreIdx);
    end else begin
      if (popOk) head <= head + SLOT_W'(1);
      case ({pushOk, popOk})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_comb begin
    strb             = '0;
    strb.push        = pushOk;
    strb.restore     = rstOk;
    strb.pushSlot    = SLOT_W_MAX'(head + SLOT_W'(count));
    strb.restoreSlot = SLOT_W_MAX'(head + restoreIdx);
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_live
    logic [SLOT_W-1:0] age;
    assign age          = SLOT_W'(s) - head;
    assign liveSlots[s] = (CNT_W'(age) < count);
  end
endmodule

// File: rtl/wbf_data.sv
module wbf_data
  import wbf_pkg::*;
#(
  parameter int NUM_PREGS = 160,
  parameter int DEPTH     = 8,
  parameter int ARCH_REGS = 32,
  parameter int NUM_WB    = 2,
  parameter int IDX_W     = $clog2(NUM_PREGS),
  parameter int SLOT_W    = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  wbf_strb_t               strb,
  input  logic [DEPTH-1:0]        liveSlots,
  input  logic                    setValid,
  input  logic [IDX_W-1:0]        setIdx,
  input  logic                    clrValid,
  input  logic [IDX_W-1:0]        clrIdx,
  input  logic [NUM_WB-1:0]       wbReq,
  input  logic [NUM_WB*IDX_W-1:0] wbDst,
  output logic [NUM_WB-1:0]       wbEn
);
  localparam int PAD_W = 2 ** IDX_W;
  localparam logic [NUM_PREGS-1:0] RESET_VEC =
    (NUM_PREGS'(1) << ARCH_REGS) - NUM_PREGS'(1);

  logic [NUM_PREGS-1:0] cur, curNext, gMask;
  logic [NUM_PREGS-1:0] ckpt [DEPTH];
  logic [PAD_W-1:0]     gMaskPad;

  always_comb begin
    curNext = cur;
    if (strb.restore) begin
      curNext = ckpt[strb.restoreSlot[SLOT_W-1:0]];
    end else begin
      if (clrValid && (int'(clrIdx) < NUM_PREGS)) curNext[clrIdx] = 1'b0;
      if (setValid && (int'(setIdx) < NUM_PREGS)) curNext[setIdx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur <= RESET_VEC;
    else        cur <= curNext;
  end

  always_ff @(posedge clk) begin
    if (strb.push) ckpt[strb.pushSlot[SLOT_W-1:0]] <= cur;
  end

  always_comb begin
    gMask = cur;
    for (int s = 0; s < DEPTH; s++)
      if (liveSlots[s]) gMask = gMask | ckpt[s];
  end

  assign gMaskPad = PAD_W'(gMask);

  for (genvar w = 0; w < NUM_WB; w++) begin : g_wb
    logic [IDX_W-1:0] dst;
    assign dst     = wbDst[w*IDX_W +: IDX_W];
    assign wbEn[w] = wbReq[w] && gMaskPad[dst];
  end
endmodule

// File: rtl/wb_filter.sv
module wb_filter
  import wbf_pkg::*;
#(
  parameter int NUM_PREGS = 160,
  parameter int DEPTH     = 8,
  parameter int ARCH_REGS = 32,
  parameter int NUM_WB    = 2,
  parameter int IDX_W     = $clog2(NUM_PREGS),
  parameter int SLOT_W    = $clog2(DEPTH),
  parameter int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    renSetValid,
  input  logic [IDX_W-1:0]        renSetIdx,
  input  logic                    renClrValid,
  input  logic [IDX_W-1:0]        renClrIdx,
  input  logic                    ckptPush,
  input  logic                    ckptPop,
  input  logic                    restoreValid,
  input  logic [SLOT_W-1:0]       restoreIdx,
  input  logic [NUM_WB-1:0]       wbReq,
  input  logic [NUM_WB*IDX_W-1:0] wbDst,
  output logic [NUM_WB-1:0]       wbEn,
  output logic [CNT_W-1:0]        ckptCount,
  output logic                    ckptFull
);
  wbf_strb_t        strb;
  logic [DEPTH-1:0] liveSlots;

  wbf_ctrl #(.DEPTH(DEPTH), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .push(ckptPush), .pop(ckptPop),
    .restore(restoreValid), .restoreIdx(restoreIdx),
    .strb(strb), .liveSlots(liveSlots),
    .count(ckptCount), .full(ckptFull)
  );

  wbf_data #(.NUM_PREGS(NUM_PREGS), .DEPTH(DEPTH), .ARCH_REGS(ARCH_REGS),
             .NUM_WB(NUM_WB), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) data_i (
    .clk(clk), .rst_n(rst_n),
    .strb(strb), .liveSlots(liveSlots),
    .setValid(renSetValid), .setIdx(renSetIdx),
    .clrValid(renClrValid), .clrIdx(renClrIdx),
    .wbReq(wbReq), .wbDst(wbDst), .wbEn(wbEn)
  );
endmodule

// File: rtl/wbf_chk.sv
module wbf_chk #(
  parameter int DEPTH  = 8,
  parameter int SLOT_W = 3,
  parameter int CNT_W  = 4,
  parameter int NUM_WB = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ckptPush,
  input logic              ckptPop,
  input logic              restoreValid,
  input logic [SLOT_W-1:0] restoreIdx,
  input logic [NUM_WB-1:0] wbReq,
  input logic [NUM_WB-1:0] wbEn,
  input logic [CNT_W-1:0]  ckptCount,
  input logic              ckptFull
);
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ckptCount <= CNT_W'(DEPTH));

  p_full_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ckptFull && ckptPush && !ckptPop && !restoreValid |=> $stable(ckptCount));

  p_push_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ckptPush && !ckptFull && !ckptPop && !restoreValid
      |=> ckptCount == $past(ckptCount) + CNT_W'(1));

  p_pop_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ckptPop && !ckptPush && !restoreValid && (ckptCount != '0)
      |=> ckptCount == $past(ckptCount) - CNT_W'(1));

  p_restore_depth_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restoreValid && (CNT_W'(restoreIdx) < ckptCount)
      |=> ckptCount == CNT_W'($past(restoreIdx)));

  p_push_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ckptPush && ckptPop && !ckptFull && !restoreValid && (ckptCount != '0)
      |=> $stable(ckptCount));

  p_req_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wbEn & ~wbReq) == '0);
endmodule

bind wb_filter wbf_chk #(.DEPTH(DEPTH), .SLOT_W(SLOT_W), .CNT_W(CNT_W),
                         .NUM_WB(NUM_WB)) chk_i (
  .clk(clk), .rst_n(rst_n), .ckptPush(ckptPush), .ckptPop(ckptPop),
  .restoreValid(restoreValid), .restoreIdx(restoreIdx),
  .wbReq(wbReq), .wbEn(wbEn), .ckptCount(ckptCount), .ckptFull(ckptFull)
);

// File: tb/wb_filter_tb.sv
`timescale 1ns/100ps
module wb_filter_tb_top;
  localparam int NP = 12;
  localparam int DP = 4;
  localparam int AR = 4;
  localparam int NW = 2;
  localparam int IW = 4;
  localparam int SW = 2;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic renSetValid, renClrValid, ckptPush, ckptPop, restoreValid;
  logic [IW-1:0] renSetIdx, renClrIdx;
  logic [SW-1:0] restoreIdx;
  logic [NW-1:0] wbReq, wbEn;
  logic [NW*IW-1:0] wbDst;
  logic [CW-1:0] ckptCount;
  logic ckptFull;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [NP-1:0] mCur;
  logic [NP-1:0] mQ[$];

  always #4 clk = ~clk;

  wb_filter #(.NUM_PREGS(NP), .DEPTH(DP), .ARCH_REGS(AR), .NUM_WB(NW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .renSetValid(renSetValid), .renSetIdx(renSetIdx),
    .renClrValid(renClrValid), .renClrIdx(renClrIdx),
    .ckptPush(ckptPush), .ckptPop(ckptPop),
    .restoreValid(restoreValid), .restoreIdx(restoreIdx),
    .wbReq(wbReq), .wbDst(wbDst), .wbEn(wbEn),
    .ckptCount(ckptCount), .ckptFull(ckptFull)
  );

  function automatic logic [NP-1:0] modelMask();
    logic [NP-1:0] g = mCur;
    foreach (mQ[i]) g = g | mQ[i];
    return g;
  endfunction

  task automatic chkv(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Full sweep of both ports over all 16 destination codes.
  task automatic checkAll(string tag);
    logic [NP-1:0] g = modelMask();
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      int j = 15 - i;
      wbReq = 2'b11;
      wbDst = {4'(j), 4'(i)};
      #0.1;
      chkv($sformatf("%s R2 port0 dst=%0d", tag, i), int'(wbEn[0]), (i < NP) ? int'(g[i]) : 0);
      chkv($sformatf("%s R8 port1 dst=%0d", tag, j), int'(wbEn[1]), (j < NP) ? int'(g[j]) : 0);
    end
    wbReq = 2'b00;
    wbDst = {4'd0, 4'd0};
    #0.1;
    chkv({tag, " R2 no request"}, int'(wbEn), 0);
    chkv({tag, " count"}, int'(ckptCount), mQ.size());
    chkv({tag, " R5 full"}, int'(ckptFull), int'(mQ.size() == DP));
  endtask

  task automatic step(input bit sv, input int si, input bit cv, input int ci,
                      input bit pu, input bit po, input bit rv, input int ri);
    logic [NP-1:0] saved;
    @(negedge clk);
    renSetValid = sv; renSetIdx = IW'(si);
    renClrValid = cv; renClrIdx = IW'(ci);
    ckptPush = pu; ckptPop = po;
    restoreValid = rv; restoreIdx = SW'(ri);
    @(posedge clk);
    #1;
    if (rv && ri < mQ.size()) begin
      mCur = mQ[ri];
      while (mQ.size() > ri) void'(mQ.pop_back());
    end else begin
      saved = mCur;
      if (po && mQ.size() > 0) void'(mQ.pop_front());
      if (pu && (mQ.size() + (po && mQ.size() > 0 ? 1 : 0)) < DP) mQ.push_back(saved);
      if (cv && ci < NP) mCur[ci] = 1'b0;
      if (sv && si < NP) mCur[si] = 1'b1;
    end
    renSetValid = 0; renClrValid = 0; ckptPush = 0; ckptPop = 0; restoreValid = 0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    renSetValid = 0; renSetIdx = '0; renClrValid = 0; renClrIdx = '0;
    ckptPush = 0; ckptPop = 0; restoreValid = 0; restoreIdx = '0;
    wbReq = '0; wbDst = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    mCur = 12'h00f;
    checkAll("R1 reset");

    step(1, 8, 1, 2, 0, 0, 0, 0);  checkAll("R3 set8 clr2");
    step(1, 9, 1, 9, 0, 0, 0, 0);  checkAll("R3 set wins");
    step(0, 0, 1, 3, 1, 0, 0, 0);  checkAll("R4 push with clear");
    step(0, 0, 1, 0, 0, 0, 0, 0);  checkAll("R4 bit held by snapshot");
    step(1, 5, 0, 0, 1, 0, 0, 0);  checkAll("R4 second push");
    step(0, 0, 1, 1, 1, 0, 0, 0);  checkAll("R4 third push");
    step(1, 6, 0, 0, 1, 0, 0, 0);  checkAll("R5 fill");
    step(1, 10, 0, 0, 1, 0, 0, 0); checkAll("R5 push on full");
    step(0, 0, 0, 0, 0, 1, 0, 0);  checkAll("R6 commit oldest");
    step(1, 11, 0, 0, 1, 1, 0, 0); checkAll("R9 push and commit");
    step(0, 0, 0, 0, 0, 0, 1, 3);  checkAll("R7 restore out of range");
    step(1, 7, 1, 4, 1, 1, 1, 1);  checkAll("R7 restore overrides");
    step(1, 2, 0, 0, 1, 0, 1, 3);  checkAll("R7 bad restore, push proceeds");
    step(0, 0, 0, 0, 0, 0, 1, 0);  checkAll("R7 restore oldest");
    step(0, 0, 0, 0, 0, 1, 0, 0);  checkAll("R6 commit on empty");

    for (int k = 0; k < 60; k++) begin
      step(1, k % 14, 1, (k * 7 + 3) % 13, (k % 3) != 2, (k % 4) == 3,
           (k % 11) == 10, k % 4);
      checkAll("R3 R4 R6 R7 R9 sweep");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule